// File: doc/BRIEF.md
# Triggered Lookback Sample Pipeline

The block keeps a running history of digitized samples for a bank of channels. On every clock one sample word (all channels side by side) is written into a ring of slots, without pause. A trigger input picks out history from a fixed distance in the past. With the default parameters the ring has 192 slots and the trigger selects the slot written 160 clocks earlier. That distance matches the time the trigger decision takes to reach the block.

A mode input chooses, per trigger, one sample or three consecutive samples. Selected slots are locked against overwrite, and their addresses wait in a short queue of pending triggers. A sequencer turns each pending trigger into an output frame. The frame is a header word followed by its sample words, and each sample costs a fixed 141 clocks of readout. Because writing never stops during readout, the block has no dead time. The price is that a trigger can be dropped when a slot it needs is locked, when that slot holds no valid sample, or when the queue is full. A one-cycle overflow pulse reports each dropped trigger.

Top module: `lookback_pipe`

## Requirements
- R1: While reset is held and in the first cycles after reset, outValid, busy and overflow are 0.
- R2: A trigger sampled on the clock edge that writes sample n selects sample n-160 as its first sample, stored in a ring of 192 slots that are filled in increasing address order, starting at address 0 with the first sample after reset.
- R3: With modeTriple=0 a trigger selects one sample. With modeTriple=1 it selects three consecutive samples (n-160, n-159, n-158). The mode is taken per trigger.
- R4: Each frame starts with a header word flagged by outFirst, with bits [7:0] = ring address of the first selected slot, bits [15:8] = trigger count, bit 16 = mode, and all other bits 0. The sample words follow in time order, the final one flagged by outLast. Channel c occupies bits [c*12 +: 12] of a sample word.
- R5: Sample k (k from 0) of a frame appears (k+1)*141-1 cycles after its header. When another trigger is pending, the next header appears in the cycle right after the previous frame's last word.
- R6: Samples keep being written during a readout, so samples captured while a frame is being read out are returned correctly by later triggers.
- R7: A trigger that needs a slot still locked by an earlier accepted trigger is dropped, and overflow is 1 in the cycle after that trigger.
- R8: A trigger that needs a slot not yet written since reset, or a slot whose latest write was skipped because the slot was locked, is dropped with an overflow pulse.
- R9: Up to 4 accepted triggers wait in a queue and are read out in arrival order. A trigger arriving while the queue holds 4 entries is dropped with an overflow pulse.
- R10: busy is 1 whenever a frame is being read out or the queue is not empty, and it returns to 0 once all frames have been sent.
- R11: The trigger count in the header starts at 0 after reset and advances by one for each accepted trigger only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 48 | One sample word, 4 channels of 12 bits |
| trigIn | input | 1 | Trigger, one pulse per event |
| modeTriple | input | 1 | 0: one sample per trigger, 1: three samples |
| outData | output | 48 | Header or sample word |
| outValid | output | 1 | outData carries a word this cycle |
| outFirst | output | 1 | Header word of a frame |
| outLast | output | 1 | Final sample word of a frame |
| busy | output | 1 | Readout in progress or triggers pending |
| overflow | output | 1 | A trigger was dropped in the previous cycle |

## Verification
The sample stream is a counter-derived pattern that differs per channel, so any error in lookback distance or slot addressing shows up as a wrong value. Triggers are placed one cycle either side of the ring-fill boundary to fix the exact lookback, and next to a slot whose write was skipped during a readout. A neighbouring trigger then shows that writing continued, while the trigger on the skipped slot is refused. Triple-mode triggers one cycle apart and three cycles apart separate the overlap from back-to-back queuing. A burst of six single triggers tells a filled queue apart from one that is merely busy.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  // strobes from the sequencer to the sample ring
  typedef struct packed {
    logic lockSet;     // accept trigger: lock its slots
    logic lockTriple;  // lock three consecutive slots instead of one
    logic unlock;      // release the slot being emitted now
  } ringCtl_t;

  // address a+k on a ring of the given depth
  function automatic int ringStep(int a, int k, int depth);
    int s;
    s = a + k;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/lbp_ring.sv
module lbp_ring
  import lbp_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 192,
  parameter int LOOKBACK = 160,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = CHANNELS * SAMPLE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] sampleIn,
  input  ringCtl_t      ctl,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic [AW-1:0] baseAddr,
  output logic          blocked1,
  output logic          blocked3
);

  logic [DW-1:0]    ring [DEPTH];
  logic [AW-1:0]    wp;
  logic [DEPTH-1:0] locked;
  logic [DEPTH-1:0] stale;
  logic [AW-1:0]    slot1, slot2;

  always_comb begin
    int b;
    b = int'(wp) - LOOKBACK;
    if (b < 0) b = b + DEPTH;
    baseAddr = AW'(b);
    slot1    = AW'(ringStep(b, 1, DEPTH));
    slot2    = AW'(ringStep(b, 2, DEPTH));
  end

  assign blocked1 = locked[baseAddr] | stale[baseAddr];
  assign blocked3 = blocked1 | locked[slot1] | stale[slot1] | locked[slot2] | stale[slot2];
  assign rdData   = ring[rdAddr];

  // a locked slot keeps its content; the skipped write leaves it stale
  always_ff @(posedge clk) begin
    if (!locked[wp]) ring[wp] <= sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp     <= '0;
      locked <= '0;
      stale  <= '1;
    end else begin
      wp        <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      stale[wp] <= locked[wp];
      if (ctl.unlock) locked[rdAddr] <= 1'b0;
      if (ctl.lockSet) begin
        locked[baseAddr] <= 1'b1;
        if (ctl.lockTriple) begin
          locked[slot1] <= 1'b1;
          locked[slot2] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lbp_ctrl.sv
module lbp_ctrl
  import lbp_pkg::*;
#(
  parameter int DEPTH  = 192,
  parameter int DW     = 48,
  parameter int CYC    = 141,
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CW  = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigIn,
  input  logic          modeTriple,
  input  logic [AW-1:0] baseAddr,
  input  logic          blocked1,
  input  logic          blocked3,
  input  logic [DW-1:0] rdData,
  output ringCtl_t      ctl,
  output logic [AW-1:0] rdAddr,
  output logic [DW-1:0] outData,
  output logic          outValid,
  output logic          outFirst,
  output logic          outLast,
  output logic          busy,
  output logic          overflow
);

  // pending trigger queue
  logic [AW-1:0]    qAddr [QDEPTH];
  logic             qMode [QDEPTH];
  logic [CNT_W-1:0] qCnt  [QDEPTH];
  logic [QAW-1:0]   head, tail;
  logic [QAW:0]     level;
  logic [CNT_W-1:0] trigCnt;

  // frame sequencer state
  logic             active;
  logic [AW-1:0]    curAddr;
  logic             curMode;
  logic [CNT_W-1:0] curCnt;
  logic [1:0]       sampIdx;
  logic [CW-1:0]    inner;

  logic accept, full, emitHeader, emitSample, lastWord, load;
  logic [DW-1:0] hdr;

  assign full       = (level == (QAW+1)'(QDEPTH));
  assign accept     = trigIn && !full && !(modeTriple ? blocked3 : blocked1);
  assign emitHeader = active && (inner == '0) && (sampIdx == '0);
  assign emitSample = active && (inner == CW'(CYC - 1));
  assign lastWord   = emitSample && (sampIdx == (curMode ? 2'd2 : 2'd0));
  assign load       = (!active || lastWord) && (level != '0);
  assign rdAddr     = AW'(ringStep(int'(curAddr), int'(sampIdx), DEPTH));

  always_comb begin
    hdr = '0;
    hdr[AW-1:0]        = curAddr;
    hdr[AW +: CNT_W]   = curCnt;
    hdr[AW + CNT_W]    = curMode;
  end

  assign outValid = emitHeader | emitSample;
  assign outFirst = emitHeader;
  assign outLast  = lastWord;
  assign outData  = emitHeader ? hdr : (emitSample ? rdData : '0);
  assign busy     = active || (level != '0);

  assign ctl.lockSet    = accept;
  assign ctl.lockTriple = modeTriple;
  assign ctl.unlock     = emitSample;

  always_ff @(posedge clk) begin
    if (accept) begin
      qAddr[tail] <= baseAddr;
      qMode[tail] <= modeTriple;
      qCnt[tail]  <= trigCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head     <= '0;
      tail     <= '0;
      level    <= '0;
      trigCnt  <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= trigIn && !accept;
      if (accept) begin
        tail    <= (tail == QAW'(QDEPTH - 1)) ? '0 : tail + 1'b1;
        trigCnt <= trigCnt + 1'b1;
      end
      if (load) head <= (head == QAW'(QDEPTH - 1)) ? '0 : head + 1'b1;
      case ({accept, load})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      curAddr <= '0;
      curMode <= 1'b0;
      curCnt  <= '0;
      sampIdx <= '0;
      inner   <= '0;
    end else if (load) begin
      active  <= 1'b1;
      curAddr <= qAddr[head];
      curMode <= qMode[head];
      curCnt  <= qCnt[head];
      sampIdx <= '0;
      inner   <= '0;
    end else if (active) begin
      if (emitSample) begin
        inner   <= '0;
        sampIdx <= sampIdx + 1'b1;
        if (lastWord) active <= 1'b0;
      end else begin
        inner <= inner + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lookback_pipe.sv
module lookback_pipe
  import lbp_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 192,
  parameter int LOOKBACK = 160,
  parameter int CYC      = 141,
  parameter int QDEPTH   = 4,
  parameter int CNT_W    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = CHANNELS * SAMPLE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] sampleIn,
  input  logic          trigIn,
  input  logic          modeTriple,
  output logic [DW-1:0] outData,
  output logic          outValid,
  output logic          outFirst,
  output logic          outLast,
  output logic          busy,
  output logic          overflow
);

  ringCtl_t      ctl;
  logic [AW-1:0] rdAddr, baseAddr;
  logic [DW-1:0] rdData;
  logic          blocked1, blocked3;

  lbp_ring #(
    .CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .LOOKBACK(LOOKBACK)
  ) u_ring (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .ctl(ctl), .rdAddr(rdAddr),
    .rdData(rdData), .baseAddr(baseAddr), .blocked1(blocked1), .blocked3(blocked3)
  );

  lbp_ctrl #(
    .DEPTH(DEPTH), .DW(DW), .CYC(CYC), .QDEPTH(QDEPTH), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .modeTriple(modeTriple),
    .baseAddr(baseAddr), .blocked1(blocked1), .blocked3(blocked3), .rdData(rdData),
    .ctl(ctl), .rdAddr(rdAddr), .outData(outData), .outValid(outValid),
    .outFirst(outFirst), .outLast(outLast), .busy(busy), .overflow(overflow)
  );

endmodule

// File: rtl/lookback_pipe_checks.sv
module lookback_pipe_checks (
  input logic clk,
  input logic rstN,
  input logic trigIn,
  input logic outValid,
  input logic outFirst,
  input logic outLast,
  input logic busy,
  input logic overflow
);

  AST_FIRST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid); // R4

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R4

  AST_HEADER_NOT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    !(outFirst && outLast)); // R4

  AST_GAP_AFTER_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |=> !outValid); // R5

  AST_GAP_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outFirst && !outLast) |=> !outValid); // R5

  AST_BUSY_DURING_WORD: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy); // R10

  AST_OVERFLOW_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> $past(trigIn)); // R7

endmodule

bind lookback_pipe lookback_pipe_checks u_checks (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .outValid(outValid), .outFirst(outFirst),
  .outLast(outLast), .busy(busy), .overflow(overflow)
);

// File: tb/test_lookback_pipe.sv
module test_lookback_pipe;

  localparam int DW = 48;
  localparam int CYC = 141;
  localparam int RLS = 5;   // stamp at which reset is released

  typedef struct {
    logic [DW-1:0] data;
    bit            first;
    bit            last;
    int            off;
    int            gap;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          trigIn = 1'b0;
  logic          modeTriple = 1'b0;
  logic [DW-1:0] outData;
  logic          outValid, outFirst, outLast, busy, overflow;

  int nChecks = 0;
  int nFail = 0;
  int stamp = 0;
  int accCnt = 0;
  int hdrStamp = 0;
  int lastStamp = 0;
  item_t sb[$];

  lookback_pipe i_lookback_pipe (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .trigIn(trigIn), .modeTriple(modeTriple),
    .outData(outData), .outValid(outValid), .outFirst(outFirst), .outLast(outLast),
    .busy(busy), .overflow(overflow)
  );

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] pat(int s);
    logic [DW-1:0] w;
    for (int c = 0; c < 4; c++) w[c*12 +: 12] = 12'((s * 3 + c * 401) & 12'hFFF);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // stimulus time base: each negedge advances the stamp and the sample
  always @(negedge clk) begin
    stamp    <= stamp + 1;
    sampleIn <= pat(stamp + 1);
    rstN     <= (stamp + 1 >= RLS);
  end

  // driver: fire a trigger at stamp s and push the frame it should produce
  task automatic fire(input int s, input bit triple, input bit expAccept,
                      input int gap, input string req);
    item_t it;
    while (stamp < s) begin
      @(negedge clk);
      #1;
    end
    trigIn     = 1'b1;
    modeTriple = triple;
    if (expAccept) begin
      it.data  = '0;
      it.data[7:0]  = 8'((s - 160 - RLS) % 192);
      it.data[15:8] = 8'(accCnt);
      it.data[16]   = triple;
      it.first = 1'b1; it.last = 1'b0; it.off = 0; it.gap = gap; it.req = req;
      sb.push_back(it);
      for (int k = 0; k < (triple ? 3 : 1); k++) begin
        it.data  = pat(s - 160 + k);
        it.first = 1'b0;
        it.last  = (k == (triple ? 2 : 0));
        it.off   = (k + 1) * CYC - 1;
        it.gap   = -1;
        sb.push_back(it);
      end
      accCnt++;
    end
    @(negedge clk);
    #1;
    chk(overflow == !expAccept, req, "overflow after trigger", 64'(overflow), 64'(!expAccept));
    if (expAccept) chk(busy == 1'b1, "R10", "busy after accepted trigger", 64'(busy), 64'd1);
    trigIn = 1'b0;
  endtask

  // monitor: compare every output word with the scoreboard
  always @(negedge clk) begin : monitor
    item_t it;
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4", "unexpected output word", 64'(outData), 64'd0);
      end else begin
        it = sb.pop_front();
        chk(outData == it.data, it.req, "word content", 64'(outData), 64'(it.data));
        chk(outFirst == it.first && outLast == it.last, "R4", "frame markers",
            64'({outFirst, outLast}), 64'({it.first, it.last}));
        if (it.first) begin
          if (it.gap >= 0)
            chk(stamp - lastStamp == it.gap, "R5", "back-to-back header",
                64'(stamp - lastStamp), 64'(it.gap));
          hdrStamp = stamp;
        end else begin
          chk(stamp - hdrStamp == it.off, "R5", "sample spacing",
              64'(stamp - hdrStamp), 64'(it.off));
        end
        lastStamp = stamp;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    int s0, sa, sb0;
    @(negedge clk); #1;
    @(negedge clk); #1;
    chk(!outValid && !busy && !overflow, "R1", "outputs in reset",
        64'({outValid, busy, overflow}), 64'd0);
    while (stamp < RLS + 5) begin @(negedge clk); #1; end
    chk(!outValid && !busy && !overflow, "R1", "outputs after reset",
        64'({outValid, busy, overflow}), 64'd0);

    // ring not yet filled, then the exact fill boundary
    fire(RLS + 50, 1'b0, 1'b0, -1, "R8");
    fire(RLS + 159, 1'b0, 1'b0, -1, "R8");
    s0 = RLS + 160;
    fire(s0, 1'b0, 1'b1, -1, "R2");

    // slot whose write was skipped while locked, and its neighbour
    fire(s0 + 192, 1'b0, 1'b0, -1, "R8");
    fire(s0 + 193, 1'b0, 1'b1, -1, "R6");

    // triple mode: overlapping trigger dropped, spaced one queued back to back
    sa = s0 + 600;
    fire(sa, 1'b1, 1'b1, -1, "R3");
    fire(sa + 1, 1'b1, 1'b0, -1, "R7");
    fire(sa + 3, 1'b1, 1'b1, 1, "R9");

    // burst of single triggers fills the queue; counts stay contiguous (R11)
    sb0 = sa + 1246;
    for (int i = 0; i < 5; i++) fire(sb0 + 2 * i, 1'b0, 1'b1, (i == 0) ? -1 : 1, "R11");
    fire(sb0 + 10, 1'b0, 1'b0, -1, "R9");

    while (stamp < sb0 + 760) begin @(negedge clk); #1; end
    chk(busy == 1'b0, "R10", "busy after all frames", 64'(busy), 64'd0);
    chk(sb.size() == 0, "R9", "frames still missing", 64'(sb.size()), 64'd0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule